// File: doc/BRIEF.md
# Self-Calibrating Input Delay Controller

This block finds a good capture point for a source-synchronous input bus whose forwarded clock edges line up with the data transitions. A spare programmable delay line carries the forwarded clock. A flip-flop clocked by the buffered clock samples that delayed copy, and the controller reads the flip-flop output on `smp_i`. The controller steps the spare line's tap (`cal_tap_o`) from zero upward. At each step it looks for the taps where the sampled level flips. Those two taps bound the valid window, and their midpoint becomes the common setting for every data-input delay line (`data_tap_o`).

The spare line is separate from the data lines, so the sweep never moves the data taps until a new centre is committed. Live capture therefore keeps running while calibration is in progress. A sweep can run once per `start_i` pulse. It can also repeat without end while `cont_i` is held high. The delay lines, the capture flip-flops and any per-bit deskew are outside this block.

Top module: `dly_cal_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `cal_tap_o` and every lane of `data_tap_o` to `DEF_TAP` (16) and clears `done_o` and `err_o`. This applies in any state, including mid-sweep, and the controller returns to idle.
- R2: A `start_i` seen in idle begins a sweep at tap 0. The tap rises by exactly one after each measurement. Each tap is measured after `SETTLE` (4) wait cycles, so the result for tap t is due (t+1)·(SETTLE+CONFIRM) cycles after the start edge.
- R3: A level is accepted only after `CONFIRM` (3) consecutive identical samples. A differing sample restarts the run, so a one-cycle glitch delays the decision and does not create an edge.
- R4: The first accepted level of a sweep is the reference. A tap whose accepted level differs from the previous accepted level is an edge. The second edge ends the sweep.
- R5: The committed centre is (first edge + second edge) >> 1, computed without overflow and truncated.
- R6: On commit, every lane i of `data_tap_o` (bits [i·TAP_W +: TAP_W]) takes the centre. This happens in the same cycle as a one-cycle `done_o` pulse, which falls at the decision edge of the second-edge tap.
- R7: `data_tap_o` never changes except in a cycle where `done_o` is high.
- R8: If the tap at all-ones is measured and fewer than two edges have been found, `err_o` pulses for one cycle, `done_o` stays low and `data_tap_o` keeps its previous value.
- R9: With `cont_i` low when a sweep ends, the controller goes idle and produces no further pulses. `start_i` has no effect while a sweep is running.
- R10: With `cont_i` high when a sweep ends (commit or error), a new sweep starts at tap 0 on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a sweep when idle |
| cont_i | input | 1 | High: repeat sweeps; low: one-shot |
| smp_i | input | 1 | Output of the flip-flop sampling the delayed forwarded clock |
| cal_tap_o | output | TAP_W | Tap setting of the spare calibration delay line |
| data_tap_o | output | NBITS·TAP_W | Common tap setting, replicated once per data lane |
| done_o | output | 1 | One-cycle pulse when a new centre is committed |
| err_o | output | 1 | One-cycle pulse when a sweep ends without two edges |

## Verification
Every sweep result is due a fixed number of cycles after the edge that accepted `start_i`. A commit lands (B+1)·7 cycles later, where B is the tap of the second edge, and a failed sweep lands 32·7 = 224 cycles later. The bench models the sampling flip-flop as a window on `cal_tap_o`. It counts falling edges from the start edge until `done_o` or `err_o` appears and compares that count with the formula. It then reads the lanes in the same half-cycle and checks that the pulse is gone one cycle later. A glitch injected on the first confirm sample of a tap must add exactly one cycle. During a continuous second sweep, the count restarts at the edge that produced the first `done_o`.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;

    // phases of the sample-qualification filter
    typedef enum logic [1:0] {
        F_OFF  = 2'd0,
        F_WAIT = 2'd1,
        F_RUN  = 2'd2
    } flt_ph_e;

    // sweep sequencer states
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_SWEEP = 1'b1
    } seq_st_e;

endpackage

// File: rtl/dly_cal_filter.sv
// Waits SETTLE cycles after every arm, then accepts a level once CONFIRM
// consecutive identical samples have been seen.
module dly_cal_filter
    import dly_cal_pkg::*;
#(
    parameter int SETTLE  = 4,
    parameter int CONFIRM = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic smp_i,
    output logic acc_vld_o,
    output logic acc_lvl_o
);

    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam int RUN_W = $clog2(CONFIRM + 1);

    typedef struct packed {
        flt_ph_e            ph;
        logic [CNT_W-1:0]   cnt;
        logic [RUN_W-1:0]   run;
        logic               lvl;
    } flt_t;

    flt_t flt_q, flt_d;

    always_comb begin
        flt_d     = flt_q;
        acc_vld_o = 1'b0;
        unique case (flt_q.ph)
            F_WAIT: begin
                if (flt_q.cnt == CNT_W'(SETTLE - 1)) begin
                    flt_d.ph  = F_RUN;
                    flt_d.run = '0;
                end else begin
                    flt_d.cnt = flt_q.cnt + CNT_W'(1);
                end
            end
            F_RUN: begin
                if ((flt_q.run == '0) || (smp_i != flt_q.lvl)) begin
                    flt_d.lvl = smp_i;
                    flt_d.run = RUN_W'(1);
                end else begin
                    flt_d.run = flt_q.run + RUN_W'(1);
                end
                if (flt_d.run == RUN_W'(CONFIRM)) begin
                    acc_vld_o = 1'b1;
                    flt_d.ph  = F_OFF;
                end
            end
            default: ;
        endcase
        acc_lvl_o = flt_d.lvl;
        if (arm_i) begin
            flt_d.ph  = F_WAIT;
            flt_d.cnt = '0;
            flt_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q.ph  <= F_OFF;
            flt_q.cnt <= '0;
            flt_q.run <= '0;
            flt_q.lvl <= 1'b0;
        end else begin
            flt_q <= flt_d;
        end
    end

endmodule

// File: rtl/dly_cal_seq.sv
// Steps the calibration tap, tracks level changes and decides commit or failure.
module dly_cal_seq
    import dly_cal_pkg::*;
#(
    parameter int TAP_W   = 5,
    parameter int DEF_TAP = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             acc_vld_i,
    input  logic             acc_lvl_i,
    output logic             arm_o,
    output logic [TAP_W-1:0] cal_tap_o,
    output logic             commit_o,
    output logic             fail_o,
    output logic [TAP_W-1:0] centre_o
);

    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    typedef struct packed {
        seq_st_e          st;
        logic [TAP_W-1:0] tap;
        logic             ref_lvl;
        logic             first;
        logic             have_e1;
        logic [TAP_W-1:0] e1;
    } seq_t;

    seq_t seq_q, seq_d;
    logic hit, finish;
    logic [TAP_W:0] span_sum;

    assign span_sum  = {1'b0, seq_q.e1} + {1'b0, seq_q.tap};
    assign centre_o  = span_sum[TAP_W:1];
    assign cal_tap_o = seq_q.tap;

    always_comb begin
        seq_d    = seq_q;
        arm_o    = 1'b0;
        commit_o = 1'b0;
        fail_o   = 1'b0;
        hit      = 1'b0;
        finish   = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.st      = S_SWEEP;
                    seq_d.tap     = '0;
                    seq_d.first   = 1'b1;
                    seq_d.have_e1 = 1'b0;
                    arm_o         = 1'b1;
                end
            end
            S_SWEEP: begin
                if (acc_vld_i) begin
                    hit           = !seq_q.first && (acc_lvl_i != seq_q.ref_lvl);
                    seq_d.first   = 1'b0;
                    seq_d.ref_lvl = acc_lvl_i;
                    if (hit && seq_q.have_e1) begin
                        commit_o = 1'b1;
                        finish   = 1'b1;
                    end else begin
                        if (hit) begin
                            seq_d.e1      = seq_q.tap;
                            seq_d.have_e1 = 1'b1;
                        end
                        if (seq_q.tap == TAP_MAX) begin
                            fail_o = 1'b1;
                            finish = 1'b1;
                        end else begin
                            seq_d.tap = seq_q.tap + TAP_W'(1);
                            arm_o     = 1'b1;
                        end
                    end
                    if (finish) begin
                        if (cont_i) begin
                            seq_d.tap     = '0;
                            seq_d.first   = 1'b1;
                            seq_d.have_e1 = 1'b0;
                            arm_o         = 1'b1;
                        end else begin
                            seq_d.st = S_IDLE;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st      <= S_IDLE;
            seq_q.tap     <= TAP_W'(DEF_TAP);
            seq_q.ref_lvl <= 1'b0;
            seq_q.first   <= 1'b0;
            seq_q.have_e1 <= 1'b0;
            seq_q.e1      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/dly_cal_commit.sv
// Holds the committed data tap and fans it out to every data lane.
module dly_cal_commit #(
    parameter int TAP_W   = 5,
    parameter int NBITS   = 16,
    parameter int DEF_TAP = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commit_i,
    input  logic                   fail_i,
    input  logic [TAP_W-1:0]       centre_i,
    output logic [NBITS*TAP_W-1:0] data_tap_o,
    output logic                   done_o,
    output logic                   err_o
);

    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             done;
        logic             err;
    } cmt_t;

    cmt_t cmt_q, cmt_d;

    always_comb begin
        cmt_d      = cmt_q;
        cmt_d.done = commit_i;
        cmt_d.err  = fail_i;
        if (commit_i) begin
            cmt_d.tap = centre_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmt_q.tap  <= TAP_W'(DEF_TAP);
            cmt_q.done <= 1'b0;
            cmt_q.err  <= 1'b0;
        end else begin
            cmt_q <= cmt_d;
        end
    end

    for (genvar g = 0; g < NBITS; g++) begin : g_lane
        assign data_tap_o[g*TAP_W +: TAP_W] = cmt_q.tap;
    end

    assign done_o = cmt_q.done;
    assign err_o  = cmt_q.err;

endmodule

// File: rtl/dly_cal_ctrl.sv
module dly_cal_ctrl #(
    parameter int NBITS   = 16,
    parameter int TAP_W   = 5,
    parameter int DEF_TAP = 16,
    parameter int SETTLE  = 4,
    parameter int CONFIRM = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   cont_i,
    input  logic                   smp_i,
    output logic [TAP_W-1:0]       cal_tap_o,
    output logic [NBITS*TAP_W-1:0] data_tap_o,
    output logic                   done_o,
    output logic                   err_o
);

    logic             arm;
    logic             acc_vld;
    logic             acc_lvl;
    logic             commit;
    logic             fail;
    logic [TAP_W-1:0] centre;

    dly_cal_filter #(
        .SETTLE  (SETTLE),
        .CONFIRM (CONFIRM)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .smp_i     (smp_i),
        .acc_vld_o (acc_vld),
        .acc_lvl_o (acc_lvl)
    );

    dly_cal_seq #(
        .TAP_W   (TAP_W),
        .DEF_TAP (DEF_TAP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cont_i    (cont_i),
        .acc_vld_i (acc_vld),
        .acc_lvl_i (acc_lvl),
        .arm_o     (arm),
        .cal_tap_o (cal_tap_o),
        .commit_o  (commit),
        .fail_o    (fail),
        .centre_o  (centre)
    );

    dly_cal_commit #(
        .TAP_W   (TAP_W),
        .NBITS   (NBITS),
        .DEF_TAP (DEF_TAP)
    ) u_commit (
        .clk        (clk),
        .rst        (rst),
        .commit_i   (commit),
        .fail_i     (fail),
        .centre_i   (centre),
        .data_tap_o (data_tap_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/dly_cal_chk.sv
module dly_cal_chk #(
    parameter int NBITS = 16,
    parameter int TAP_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic [TAP_W-1:0]       cal_tap_o,
    input logic [NBITS*TAP_W-1:0] data_tap_o,
    input logic                   done_o,
    input logic                   err_o
);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_tap_o) |-> done_o);

    // R8
    err_keep_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(data_tap_o) && !done_o));

    // R2
    tap_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cal_tap_o) |->
            ((cal_tap_o == TAP_W'($past(cal_tap_o) + 1'b1)) || (cal_tap_o == '0)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

endmodule

bind dly_cal_ctrl dly_cal_chk #(
    .NBITS (NBITS),
    .TAP_W (TAP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cal_tap_o  (cal_tap_o),
    .data_tap_o (data_tap_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/dly_cal_ctrl_tb.sv
`timescale 1ns/1ps
module dly_cal_ctrl_tb;

    localparam int NB   = 16;
    localparam int TW   = 5;
    localparam int DEF  = 16;
    localparam int ST   = 4;
    localparam int CF   = 3;
    localparam int PER  = ST + CF;
    localparam int TMAX = 31;

    // lo, hi (sample is 1 for lo <= tap < hi), expected centre, error flag
    localparam int VEC [6][4] = '{
        '{ 5, 12,  8, 0},
        '{ 1, 30, 15, 0},
        '{ 3,  4,  3, 0},
        '{20, 32,  0, 1},
        '{ 0, 10,  0, 1},
        '{30, 31, 30, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cont = 1'b0;
    logic glitch = 1'b0;
    int   win_lo = 0;
    int   win_hi = 0;
    logic smp;
    logic [TW-1:0]    cal_tap;
    logic [NB*TW-1:0] data_tap;
    logic done, err;
    int checks = 0;
    int errors = 0;
    int exp_data = DEF;

    always #10 clk = ~clk;

    assign smp = glitch ^ ((int'(cal_tap) >= win_lo) && (int'(cal_tap) < win_hi));

    dly_cal_ctrl #(
        .NBITS (NB), .TAP_W (TW), .DEF_TAP (DEF), .SETTLE (ST), .CONFIRM (CF)
    ) u_dut (
        .clk (clk), .rst (rst), .start_i (start), .cont_i (cont), .smp_i (smp),
        .cal_tap_o (cal_tap), .data_tap_o (data_tap), .done_o (done), .err_o (err)
    );

    function automatic bit lanes_are(int v);
        for (int l = 0; l < NB; l++)
            if (int'(data_tap[l*TW +: TW]) != v) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sweep: optional start pulse, optional glitch and extra start at given counts
    task automatic sweep(input int lo, input int hi, input int mid, input int is_err,
                         input int exp_n, input int gl_at, input int st_at,
                         input bit kick, input int n0);
        int n;
        bit held;
        win_lo = lo;
        win_hi = hi;
        n = n0;
        held = 1'b1;
        if (kick) begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!(done || err) && n < 400) begin
            if (!lanes_are(exp_data)) held = 1'b0;
            glitch = (n == gl_at);
            start  = (n == st_at);
            @(negedge clk);
            n++;
        end
        glitch = 1'b0;
        start  = 1'b0;
        check(held, "R7 data taps held during sweep", int'(data_tap[TW-1:0]), exp_data);
        if (is_err != 0) begin
            check(err && !done, "R8 error pulse without done", int'({done, err}), 1);
            check(lanes_are(exp_data), "R8 data taps kept on failure",
                  int'(data_tap[TW-1:0]), exp_data);
        end else begin
            check(done && !err, "R6 done pulse on commit", int'({done, err}), 2);
            check(lanes_are(mid), "R5 R6 centre on every lane",
                  int'(data_tap[(NB-1)*TW +: TW]), mid);
            exp_data = mid;
        end
        check(n == exp_n, "R2 R4 result cycle", n, exp_n);
        @(negedge clk);
        check(!done && !err, "R6 R8 pulse lasts one cycle", int'({done, err}), 0);
    endtask

    initial begin
        #(20.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(lanes_are(DEF), "R1 data taps at reset", int'(data_tap[TW-1:0]), DEF);
        check(int'(cal_tap) == DEF, "R1 cal tap at reset", int'(cal_tap), DEF);
        check(!done && !err, "R1 flags at reset", int'({done, err}), 0);
        rst = 1'b0;

        // R9 idle without start: nothing happens
        win_lo = 2; win_hi = 6;
        quiet = 1;
        repeat (40) begin
            @(negedge clk);
            if (done || err || int'(cal_tap) != DEF) quiet = 0;
        end
        check(quiet == 1, "R9 idle without start", quiet, 1);

        // table walk: R4 R5 R8 and commit at the last tap
        for (int i = 0; i < 6; i++) begin
            sweep(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                  (VEC[i][3] != 0) ? (TMAX + 1) * PER : (VEC[i][1] + 1) * PER,
                  -1, -1, 1'b1, 0);
        end

        // R3 one-cycle glitch on first confirm sample of tap 2: one cycle late, same centre
        sweep(5, 12, 8, 0, 13 * PER + 1, 18, -1, 1'b1, 0);

        // R9 start during a sweep is ignored
        sweep(6, 13, 9, 0, 14 * PER, -1, 40, 1'b1, 0);

        // R10 continuous: a second sweep follows at once; R9 then stops when cont drops
        cont = 1'b1;
        sweep(5, 12, 8, 0, 13 * PER, -1, -1, 1'b1, 0);
        cont = 1'b0;
        sweep(9, 14, 11, 0, 15 * PER, -1, -1, 1'b0, 1);
        quiet = 1;
        repeat (300) begin
            @(negedge clk);
            if (done || err || !lanes_are(11)) quiet = 0;
        end
        check(quiet == 1, "R9 R10 idle after one-shot end", quiet, 1);

        // R1 reset in the middle of a sweep
        win_lo = 5; win_hi = 12;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(lanes_are(DEF), "R1 data taps after mid-sweep reset", int'(data_tap[TW-1:0]), DEF);
        check(int'(cal_tap) == DEF, "R1 cal tap after mid-sweep reset", int'(cal_tap), DEF);
        rst = 1'b0;
        exp_data = DEF;
        quiet = 1;
        repeat (120) begin
            @(negedge clk);
            if (done || err || int'(cal_tap) != DEF) quiet = 0;
        end
        check(quiet == 1, "R1 sweep abandoned after reset", quiet, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule